// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Front-End

This block is the command logic for a single 64-position digital potentiometer. A host selects it with an active-low chip select and clocks bytes in on a serial data line. The block returns read data on a serial output whose driver is enabled only while selected. Each transaction starts with an identification byte, which names the device family and the board address, and then an instruction byte, which names an operation and one of four data registers. A third byte follows for writes and reads. The wiper counter register drives the 6-bit tap select output directly: 00h is the low-end tap and 3Fh is the high-end tap.

The four data registers are backed by a modelled non-volatile array. A completed data-register write commits the registers to that array when chip select is released, and a busy timer then raises a write-in-process flag for a configurable number of clock cycles. While the flag is high, every command that modifies a register is refused, and status reads are still served. At reset the data registers and the wiper counter are reloaded from the array.

The serial port has no back-pressure. The host sets the pace through the serial clock, and the block must keep up. For this reason all serial inputs are sampled by the system clock, and the serial clock must stay in each phase for at least four system clock cycles. The host should poll status rather than stall the link.

Top module: `potctl_front`

## Requirements
- R1: The first byte after chip select falls must equal 0101_110A in binary, where A is the level on `addr_pin`. If it differs in any bit, the rest of the transaction is ignored and no register changes.
- R2: In the instruction byte, bits 7:4 hold the opcode and bits 3:2 select a data register. If bits 1:0 are not 00, the instruction is ignored.
- R3: Opcode 1010 writes the wiper counter from the low 6 bits of the next byte, and the upper two bits are discarded. `tap_sel` follows the wiper counter and does not change while the block is deselected.
- R4: Serial input is sampled on the rising serial clock edge, MSB first. Read opcodes return a byte MSB first that changes on the falling edge. Opcode 1001 returns {00, wiper counter}. Opcode 1011 returns {00, selected data register}.
- R5: Opcode 1100 writes the selected data register from the low 6 bits of the next byte. When chip select rises after that byte is complete, all four data registers are saved to the array, and `wip` is then high for exactly SAVE_CYCLES clock cycles.
- R6: If chip select rises before all 8 data bits of a write arrive, the write is dropped and no save starts.
- R7: Opcode 1101 copies the selected data register into the wiper counter with no save. Opcode 1110 copies the wiper counter into the selected data register and counts as a complete write, so it starts a save.
- R8: While `wip` is high, opcodes 1010, 1100, 1101 and 1110 are refused. Opcode 0101 still returns {0000000, wip}.
- R9: Any opcode other than 0101, 1001, 1010, 1011, 1100, 1101 and 1110 has no effect.
- R10: `miso_oe` is high only while the block is selected, and `miso` is 0 whenever `miso_oe` is low.
- R11: Reset loads the wiper counter and the four data registers from the array and clears `wip`. The array keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| addr_pin | input | 1 | Board address bit compared against the ID byte |
| miso | output | 1 | Serial read data |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |
| tap_sel | output | 6 | Selected tap, equal to the wiper counter |
| wip | output | 1 | Write-in-process flag |

## Verification
The bench flips each ID bit in turn and drives the address pin both ways. A decoder that skips one comparison would accept a foreign ID and move the wiper. It sweeps every wiper value and every unknown opcode, and it ends writes a few bits early. A design that counted bits wrongly or saved on every chip-select rise would show a spurious `wip` pulse or a changed register. During a save it issues a status read and every modifying command. A design that does not gate on the busy flag would change the tap or a register, and one that serves reads poorly would return a stale status. The bench measures the length of the `wip` pulse exactly, and it checks that a second reset restores the saved values, which catches a shadow array that is itself cleared by reset.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam int DW      = 6;
  localparam int NUM_REG = 4;
  localparam int BYTE_W  = 8;
  localparam int RSEL_W  = $clog2(NUM_REG);

  localparam logic [3:0] ID_FAMILY = 4'b0101;
  localparam logic [2:0] ID_FIXED  = 3'b110;

  localparam logic [3:0] OP_STATUS = 4'b0101;
  localparam logic [3:0] OP_RD_WCR = 4'b1001;
  localparam logic [3:0] OP_WR_WCR = 4'b1010;
  localparam logic [3:0] OP_RD_DR  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_DR2WCR = 4'b1101;
  localparam logic [3:0] OP_WCR2DR = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_READ, ST_DONE, ST_SKIP
  } cmd_state_t;

  function automatic logic op_known(input logic [3:0] op);
    return (op == OP_STATUS) || (op == OP_RD_WCR) || (op == OP_WR_WCR) ||
           (op == OP_RD_DR)  || (op == OP_WR_DR)  || (op == OP_DR2WCR) ||
           (op == OP_WCR2DR);
  endfunction

  function automatic logic op_modifies(input logic [3:0] op);
    return (op == OP_WR_WCR) || (op == OP_WR_DR) ||
           (op == OP_DR2WCR) || (op == OP_WCR2DR);
  endfunction
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/potctl_cmd.sv
module potctl_cmd
  import potctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic              addr_pin,
  input  logic              wip,
  input  logic [DW-1:0]     wcr_q,
  input  logic [DW-1:0]     dr_rd,
  output logic [RSEL_W-1:0] sel,
  output logic              wcr_we,
  output logic [DW-1:0]     wcr_wd,
  output logic              dr_we,
  output logic [DW-1:0]     dr_wd,
  output logic              save_req,
  output logic              sdo
);
  cmd_state_t        st;
  logic [2:0]        bcnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              hold, wtgt_wcr, pend;
  logic [RSEL_W-1:0] sel_q;

  logic [BYTE_W-1:0] nbyte;
  logic [3:0]        op;
  logic              byte_done, id_ok, reject, inst_go, data_go;

  assign nbyte     = {sh[BYTE_W-2:0], sdi};
  assign op        = nbyte[7:4];
  assign byte_done = cs_act && sck_rise && (bcnt == 3'd7);
  assign id_ok     = (nbyte[7:4] == ID_FAMILY) && (nbyte[3:1] == ID_FIXED) &&
                     (nbyte[0] == addr_pin);
  assign reject    = (nbyte[1:0] != 2'b00) || !op_known(op) ||
                     (op_modifies(op) && wip);
  assign inst_go   = byte_done && (st == ST_INSTR) && !reject;
  assign data_go   = byte_done && (st == ST_WDATA);

  always_comb begin
    sel    = (st == ST_INSTR) ? nbyte[3:2] : sel_q;
    wcr_we = (inst_go && op == OP_DR2WCR) || (data_go && wtgt_wcr);
    wcr_wd = (st == ST_INSTR) ? dr_rd : nbyte[DW-1:0];
    dr_we  = (inst_go && op == OP_WCR2DR) || (data_go && !wtgt_wcr);
    dr_wd  = (st == ST_INSTR) ? wcr_q : nbyte[DW-1:0];
  end

  assign save_req = cs_rise && pend;
  assign sdo      = cs_act && tx[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; bcnt <= '0; sh <= '0; tx <= '0;
      hold <= 1'b0; wtgt_wcr <= 1'b0; pend <= 1'b0; sel_q <= '0;
    end else if (cs_fall) begin
      st <= ST_ID; bcnt <= '0; tx <= '0; hold <= 1'b0; pend <= 1'b0;
    end else if (cs_rise) begin
      st <= ST_IDLE; tx <= '0; pend <= 1'b0;
    end else if (cs_act) begin
      if (sck_fall) begin
        if (hold) hold <= 1'b0;
        else      tx <= {tx[BYTE_W-2:0], 1'b0};
      end
      if (sck_rise) begin
        sh   <= nbyte;
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          case (st)
            ST_ID: st <= id_ok ? ST_INSTR : ST_SKIP;
            ST_INSTR: begin
              sel_q <= nbyte[3:2];
              if (reject) st <= ST_SKIP;
              else begin
                case (op)
                  OP_RD_WCR: begin tx <= {2'b00, wcr_q}; hold <= 1'b1; st <= ST_READ; end
                  OP_RD_DR:  begin tx <= {2'b00, dr_rd}; hold <= 1'b1; st <= ST_READ; end
                  OP_STATUS: begin tx <= {7'd0, wip};    hold <= 1'b1; st <= ST_READ; end
                  OP_WR_WCR: begin wtgt_wcr <= 1'b1; st <= ST_WDATA; end
                  OP_WR_DR:  begin wtgt_wcr <= 1'b0; st <= ST_WDATA; end
                  OP_WCR2DR: begin pend <= 1'b1; st <= ST_DONE; end
                  OP_DR2WCR: st <= ST_DONE;
                  default:   st <= ST_SKIP;
                endcase
              end
            end
            ST_WDATA: begin
              if (!wtgt_wcr) pend <= 1'b1;
              st <= ST_DONE;
            end
            ST_READ: st <= ST_DONE;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/potctl_regs.sv
module potctl_regs
  import potctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REG*DW-1:0] nv_flat,
  input  logic [RSEL_W-1:0]     sel,
  input  logic                  wcr_we,
  input  logic [DW-1:0]         wcr_wd,
  input  logic                  dr_we,
  input  logic [DW-1:0]         dr_wd,
  output logic [DW-1:0]         wcr_q,
  output logic [DW-1:0]         dr_rd,
  output logic [NUM_REG*DW-1:0] dr_flat
);
  logic [DW-1:0] dr_q [NUM_REG];

  always_ff @(posedge clk) begin
    if (!rst_n)      wcr_q <= nv_flat[DW-1:0];
    else if (wcr_we) wcr_q <= wcr_wd;
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_dr
    always_ff @(posedge clk) begin
      if (!rst_n)                            dr_q[g] <= nv_flat[g*DW +: DW];
      else if (dr_we && sel == RSEL_W'(g))   dr_q[g] <= dr_wd;
    end
    assign dr_flat[g*DW +: DW] = dr_q[g];
  end

  assign dr_rd = dr_q[sel];
endmodule

// File: rtl/potctl_nvstore.sv
module potctl_nvstore
  import potctl_pkg::*;
#(
  parameter int SAVE_CYCLES = 16,
  parameter logic [NUM_REG*DW-1:0] NV_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  save_req,
  input  logic [NUM_REG*DW-1:0] dr_flat,
  output logic [NUM_REG*DW-1:0] nv_flat,
  output logic                  wip
);
  localparam int CW = $clog2(SAVE_CYCLES + 1);

  logic [NUM_REG*DW-1:0] nv_q = NV_INIT;
  logic [CW-1:0]         cnt;

  always_ff @(posedge clk) begin
    if (save_req) nv_q <= dr_flat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (save_req)   cnt <= CW'(SAVE_CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign nv_flat = nv_q;
  assign wip     = (cnt != '0);
endmodule

// File: rtl/potctl_front.sv
module potctl_front
  import potctl_pkg::*;
#(
  parameter int SAVE_CYCLES = 16,
  parameter logic [NUM_REG*DW-1:0] NV_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          addr_pin,
  output logic          miso,
  output logic          miso_oe,
  output logic [DW-1:0] tap_sel,
  output logic          wip
);
  logic [2:0] sy;
  logic [1:0] prev_q;
  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall;
  logic [RSEL_W-1:0] sel;
  logic wcr_we, dr_we, save_req, sdo;
  logic [DW-1:0] wcr_wd, dr_wd, wcr_q, dr_rd;
  logic [NUM_REG*DW-1:0] dr_flat, nv_flat;

  potctl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mosi, sclk, cs_n}), .dout(sy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 2'b01;
    else        prev_q <= sy[1:0];
  end

  assign cs_act   = !sy[0];
  assign cs_fall  = !sy[0] &&  prev_q[0];
  assign cs_rise  =  sy[0] && !prev_q[0];
  assign sck_rise =  sy[1] && !prev_q[1];
  assign sck_fall = !sy[1] &&  prev_q[1];

  potctl_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(sy[2]), .addr_pin(addr_pin), .wip(wip), .wcr_q(wcr_q),
    .dr_rd(dr_rd), .sel(sel), .wcr_we(wcr_we), .wcr_wd(wcr_wd),
    .dr_we(dr_we), .dr_wd(dr_wd), .save_req(save_req), .sdo(sdo)
  );

  potctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .nv_flat(nv_flat), .sel(sel),
    .wcr_we(wcr_we), .wcr_wd(wcr_wd), .dr_we(dr_we), .dr_wd(dr_wd),
    .wcr_q(wcr_q), .dr_rd(dr_rd), .dr_flat(dr_flat)
  );

  potctl_nvstore #(.SAVE_CYCLES(SAVE_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .dr_flat(dr_flat),
    .nv_flat(nv_flat), .wip(wip)
  );

  assign miso    = sdo;
  assign miso_oe = cs_act;
  assign tap_sel = wcr_q;
endmodule

// File: rtl/potctl_front_chk.sv
module potctl_front_chk
  import potctl_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wip,
  input logic                  miso,
  input logic                  miso_oe,
  input logic [DW-1:0]         tap_sel,
  input logic                  cs_act,
  input logic                  save_req,
  input logic                  wcr_we,
  input logic                  dr_we,
  input logic [NUM_REG*DW-1:0] dr_flat,
  input logic [NUM_REG*DW-1:0] nv_flat
);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  a_r3_tap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> $stable(tap_sel));

  a_r5_save_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(save_req));

  a_r5_nv_held: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable(nv_flat));

  a_r8_dr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable(dr_flat));

  a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wcr_we, dr_we}));
endmodule

bind potctl_front potctl_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wip(wip), .miso(miso), .miso_oe(miso_oe),
  .tap_sel(tap_sel), .cs_act(cs_act), .save_req(save_req),
  .wcr_we(wcr_we), .dr_we(dr_we), .dr_flat(dr_flat), .nv_flat(nv_flat)
);

// File: tb/sim_potctl_front.sv
module sim_potctl_front;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int SAVE  = 1500;
  localparam int WD    = 190000;
  localparam logic [23:0] NVI = {6'h00, 6'h3F, 6'h2A, 6'h15};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, addr_pin = 1'b1;
  logic miso, miso_oe, wip;
  logic [5:0] tap_sel;

  int checks = 0, fails = 0, run = 0, last_len = 0;
  logic [5:0] wcr_m;
  logic [5:0] dr_m [4];
  logic [5:0] nv_m [4];
  logic [7:0] rd, idb;

  always #(CLK_P/2) clk = ~clk;

  potctl_front #(.SAVE_CYCLES(SAVE), .NV_INIT(NVI)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .addr_pin(addr_pin), .miso(miso), .miso_oe(miso_oe), .tap_sel(tap_sel), .wip(wip)
  );

  always @(posedge clk) begin
    if (!rst_n) run = 0;
    else if (wip) run++;
    else if (run != 0) begin last_len = run; run = 0; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = b[i]; tick(H); r[i] = miso;
      sclk = 1'b1; tick(H); sclk = 1'b0;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; tick(H); endtask
  task automatic cs_hi(); tick(H); cs_n = 1'b1; tick(H); endtask

  task automatic cmd3(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] dat,
                      output logic [7:0] r);
    logic [7:0] junk;
    cs_lo(); xbits(id, 8, junk); xbits(ins, 8, junk); xbits(dat, 8, r); cs_hi();
  endtask

  task automatic cmd2(input logic [7:0] id, input logic [7:0] ins);
    logic [7:0] junk;
    cs_lo(); xbits(id, 8, junk); xbits(ins, 8, junk); cs_hi();
  endtask

  task automatic wait_idle();
    while (wip) tick(1);
    tick(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(2);
    for (int k = 0; k < 4; k++) dr_m[k] = nv_m[k];
    wcr_m = nv_m[0];
  endtask

  initial begin
    tick(WD);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) nv_m[k] = NVI[k*6 +: 6];
    idb = 8'h5D;
    do_reset();
    // R11: reset state
    chk("R11 tap after reset", tap_sel, nv_m[0]);
    chk("R11 wip after reset", wip, 0);
    chk("R10 oe idle", miso_oe, 0);
    cmd3(idb, 8'h50, 8'h00, rd);
    chk("R8 status idle", rd, 8'h00);
    cs_lo();
    chk("R10 oe selected", miso_oe, 1);
    cs_hi();
    chk("R10 oe released", miso_oe, 0);

    // R3/R4: full wiper sweep with junk upper bits
    for (int v = 0; v < 64; v++) begin
      cmd3(idb, 8'hA0, {v[1:0] ^ 2'b10, v[5:0]}, rd);
      wcr_m = v[5:0];
      chk("R3 tap after wiper write", tap_sel, wcr_m);
      cmd3(idb, 8'h90, 8'h00, rd);
      chk("R4 wiper readback", rd, {2'b00, wcr_m});
    end

    // R5/R8: data register writes with save
    for (int k = 0; k < 4; k++) begin
      logic [5:0] val;
      val = 6'((k * 23 + 9) & 63);
      cmd3(idb, {4'hC, k[1:0], 2'b00}, {2'b10, val}, rd);
      dr_m[k] = val;
      for (int j = 0; j < 4; j++) nv_m[j] = dr_m[j];
      chk("R5 wip raised", wip, 1);
      if (k == 0) begin
        cmd3(idb, 8'h50, 8'h00, rd);
        chk("R8 status busy", rd, 8'h01);
        cmd3(idb, 8'hA0, 8'h01, rd);
        chk("R8 wiper write refused", tap_sel, wcr_m);
        cmd3(idb, 8'hC4, 8'h01, rd);
        cmd2(idb, 8'hD4);
        chk("R8 copy refused", tap_sel, wcr_m);
        chk("R8 still busy", wip, 1);
      end
      wait_idle();
      chk("R5 wip length", last_len, SAVE);
      cmd3(idb, {4'hB, k[1:0], 2'b00}, 8'h00, rd);
      chk("R4 data reg readback", rd, {2'b00, dr_m[k]});
    end
    cmd3(idb, 8'hB4, 8'h00, rd);
    chk("R8 refused dr write left reg", rd, {2'b00, dr_m[1]});

    // R1: ID bit flips and address pin
    cmd3(idb, 8'hA0, 8'h05, rd); wcr_m = 6'h05;
    for (int i = 0; i < 8; i++) begin
      cmd3(idb ^ (8'h01 << i), 8'hA0, 8'h3A, rd);
      chk("R1 bad id ignored", tap_sel, wcr_m);
    end
    cmd3(8'h5C, 8'hC0, 8'h2B, rd);
    chk("R1 bad id no save", wip, 0);
    addr_pin = 1'b0;
    cmd3(8'h5D, 8'hA0, 8'h3A, rd);
    chk("R1 address mismatch", tap_sel, wcr_m);
    cmd3(8'h5C, 8'hA0, 8'h07, rd); wcr_m = 6'h07;
    chk("R1 address zero accepted", tap_sel, wcr_m);
    addr_pin = 1'b1;

    // R2: nonzero low instruction bits
    for (int i = 1; i < 4; i++) begin
      cmd3(idb, {4'hA, 2'b00, i[1:0]}, 8'h22, rd);
      chk("R2 low bits ignored", tap_sel, wcr_m);
    end
    cmd3(idb, 8'hC1, 8'h22, rd);
    chk("R2 dr write ignored", wip, 0);

    // R9: all unknown opcodes
    for (int o = 0; o < 16; o++) begin
      if (!(o == 5 || (o >= 9 && o <= 14))) begin
        cmd3(idb, {o[3:0], 4'h0}, 8'h3A, rd);
        chk("R9 unknown op tap", tap_sel, wcr_m);
        chk("R9 unknown op no save", wip, 0);
      end
    end

    // R6: aborted writes
    cs_lo(); xbits(idb, 8, rd); xbits(8'hC4, 8, rd); xbits(8'h3F, 4, rd); cs_hi();
    chk("R6 abort no save", wip, 0);
    cmd3(idb, 8'hB4, 8'h00, rd);
    chk("R6 abort reg kept", rd, {2'b00, dr_m[1]});
    cs_lo(); xbits(idb, 8, rd); xbits(8'hC8, 8, rd); xbits(8'h3F, 7, rd); cs_hi();
    chk("R6 seven bits no save", wip, 0);
    cs_lo(); xbits(idb, 8, rd); xbits(8'hA0, 8, rd); xbits(8'h3F, 4, rd); cs_hi();
    chk("R6 abort wiper kept", tap_sel, wcr_m);

    // R7: copies
    cmd2(idb, 8'hD8); wcr_m = dr_m[2];
    chk("R7 dr to wiper", tap_sel, wcr_m);
    chk("R7 dr to wiper no save", wip, 0);
    cmd3(idb, 8'hA0, 8'hFF, rd); wcr_m = 6'h3F;
    chk("R3 high end tap", tap_sel, 6'h3F);
    last_len = 0;
    cmd2(idb, 8'hE4); dr_m[1] = wcr_m;
    for (int j = 0; j < 4; j++) nv_m[j] = dr_m[j];
    chk("R7 copy starts save", wip, 1);
    wait_idle();
    chk("R7 save length", last_len, SAVE);
    cmd3(idb, 8'hB4, 8'h00, rd);
    chk("R7 wiper to dr", rd, {2'b00, dr_m[1]});

    // R11: reload after save
    do_reset();
    chk("R11 tap from saved", tap_sel, nv_m[0]);
    chk("R11 wip cleared", wip, 0);
    cmd3(idb, 8'hBC, 8'h00, rd);
    chk("R11 dr3 reloaded", rd, {2'b00, nv_m[3]});
    cmd3(idb, 8'hB4, 8'h00, rd);
    chk("R11 dr1 reloaded", rd, {2'b00, nv_m[1]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule